// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block is the address arithmetic of a 32-bit load/store unit whose instructions are 16 bits wide. A decoder hands it an addressing-mode code, the access size and the raw displacement field taken from the instruction. Alongside these come the current base register, R0, the global base register and the program counter, where the PC input already holds the instruction address plus 4. The block returns the memory address in the same cycle. For the two auto-modify modes it also returns the new base value and a write enable for the register file. A third output flags accesses that break the alignment rule for their size.

The same adder path also forms branch targets: short and long PC-relative branches with a sign-extended, doubled displacement, and register-relative branches. Data displacements are zero-extended and scaled by the access size. Long PC-relative loads clear the two low PC bits before the add. All sums wrap modulo 2^32. The block is purely combinational and holds no state.

Top module: `ea_addr_gen`

## Requirements
- R1: Mode code 0 (register indirect) gives ea = base with no writeback.
- R2: Mode code 1 (post-increment) gives ea = base, wb_data = base + step and wb_en = 1. The step is 1, 2 or 4 for size code 0 (byte), 1 (word) or 2 (long); size code 3 is treated as long.
- R3: Mode code 2 (pre-decrement) gives ea = wb_data = base - step and wb_en = 1.
- R4: Mode code 3 gives ea = base + zext(disp[3:0]) * step.
- R5: Mode code 4 gives ea = base + R0. Mode code 6 gives ea = GBR + R0.
- R6: Mode code 5 gives ea = GBR + zext(disp[7:0]) * step.
- R7: Mode code 7 gives ea = PC + zext(disp[7:0]) * step. For long size, PC[1:0] is cleared before the add.
- R8: Mode code 8 (short branch) gives ea = PC + sext(disp[7:0]) * 2.
- R9: Mode code 9 (long branch) gives ea = PC + sext(disp[11:0]) * 2.
- R10: Mode code 10 (register branch) gives ea = PC + base.
- R11: For data modes 0 to 7, misalign is 1 exactly when a word address has bit 0 set or a long address has bits 1:0 non-zero. Byte accesses and branch modes never flag.
- R12: wb_en is 1 only in modes 1 and 2, and wb_data is 0 whenever wb_en is 0. Codes 11 to 15 are reserved and give ea = 0, wb_en = 0 and misalign = 0.
- R13: All sums and differences wrap modulo 2^32 with no other indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 4 | Addressing-mode code |
| size_i | input | 2 | Access size code |
| base_i | input | 32 | Base register value (Rn) |
| r0_i | input | 32 | Index register value |
| gbr_i | input | 32 | Global base register value |
| pc_i | input | 32 | Instruction address plus 4 |
| disp_i | input | 12 | Raw displacement field |
| ea_o | output | 32 | Effective address or branch target |
| wb_data_o | output | 32 | Updated base value |
| wb_en_o | output | 1 | Base writeback enable |
| misalign_o | output | 1 | Alignment violation |

## Verification
Directed vectors use displacements of all ones against base values near zero and near 2^32. These separate zero extension from sign extension and show that wrap-around is correct. A PC ending in 2 is paired with each size, so the long-only low-bit mask stands apart from the plain add. Random vectors sweep all sixteen mode codes and all four sizes with unconstrained operands. This exercises the scaling, the writeback gating, the reserved codes and every alignment pattern against the bench's own model.

// File: rtl/ea_pkg.sv
// Shared codes for the effective address generator.
// Assumes a 4-bit mode code and a 2-bit size code set by the decoder.
package ea_pkg;
    typedef enum logic [3:0] {
        M_IND     = 4'd0,
        M_POSTINC = 4'd1,
        M_PREDEC  = 4'd2,
        M_DISP4   = 4'd3,
        M_IDX_RN  = 4'd4,
        M_GBR_D8  = 4'd5,
        M_GBR_IDX = 4'd6,
        M_PC_D8   = 4'd7,
        M_BR8     = 4'd8,
        M_BR12    = 4'd9,
        M_BR_REG  = 4'd10
    } ea_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } ea_size_e;
endpackage

// File: rtl/ea_disp_scale.sv
// Zero-extends an unsigned displacement and scales it by the access size.
// Assumes size code 3 behaves as long.
module ea_disp_scale #(
    parameter int DW = 8,
    parameter int AW = 32
) (
    input  logic [DW-1:0] disp_i,
    input  logic [1:0]    size_i,
    output logic [AW-1:0] scaled_o
);
    localparam int PAD = AW - DW;

    logic [AW-1:0] zext;
    assign zext = {{PAD{1'b0}}, disp_i};

    // Select the scaling shift from the size code.
    always_comb begin
        unique case (size_i)
            2'd0:    scaled_o = zext;
            2'd1:    scaled_o = zext << 1;
            default: scaled_o = zext << 2;
        endcase
    end
endmodule

// File: rtl/ea_branch_calc.sv
// Forms the three branch targets from the PC: short and long signed
// displacements doubled, and the register-relative sum. Sums wrap.
module ea_branch_calc #(
    parameter int AW  = 32,
    parameter int SDW = 8,
    parameter int LDW = 12
) (
    input  logic [AW-1:0]  pc_i,
    input  logic [AW-1:0]  reg_i,
    input  logic [LDW-1:0] disp_i,
    output logic [AW-1:0]  short_tgt_o,
    output logic [AW-1:0]  long_tgt_o,
    output logic [AW-1:0]  reg_tgt_o
);
    localparam int SPAD = AW - SDW;
    localparam int LPAD = AW - LDW;

    logic [AW-1:0] s_off;
    logic [AW-1:0] l_off;

    // Sign-extend both displacement widths and double them.
    always_comb begin
        s_off = {{SPAD{disp_i[SDW-1]}}, disp_i[SDW-1:0]} << 1;
        l_off = {{LPAD{disp_i[LDW-1]}}, disp_i} << 1;
    end

    // Add the offsets to the PC.
    always_comb begin
        short_tgt_o = pc_i + s_off;
        long_tgt_o  = pc_i + l_off;
        reg_tgt_o   = pc_i + reg_i;
    end
endmodule

// File: rtl/ea_align_chk.sv
// Flags an address that breaks the natural alignment of its access size.
// Only enabled data accesses are judged.
module ea_align_chk #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    size_i,
    input  logic          en_i,
    output logic          misalign_o
);
    // Compare the low address bits against the size.
    always_comb begin
        unique case (size_i)
            2'd0:    misalign_o = 1'b0;
            2'd1:    misalign_o = en_i & addr_i[0];
            default: misalign_o = en_i & (addr_i[1:0] != 2'b00);
        endcase
    end

    // Byte accesses and disabled checks never flag.
    always_comb begin
        if (size_i == 2'd0 || !en_i)
            assert_byte_never_misaligned_R11: assert (misalign_o == 1'b0)
                else $error("byte or branch flagged misaligned");
    end
endmodule

// File: rtl/ea_addr_gen.sv
// Effective address generator: data addressing modes, base writeback
// for post-increment and pre-decrement, and branch targets.
// Assumes pc_i already holds the instruction address plus 4. Purely
// combinational; every sum wraps modulo 2^AW.
module ea_addr_gen
    import ea_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DFW = 12
) (
    input  logic [3:0]     mode_i,
    input  logic [1:0]     size_i,
    input  logic [AW-1:0]  base_i,
    input  logic [AW-1:0]  r0_i,
    input  logic [AW-1:0]  gbr_i,
    input  logic [AW-1:0]  pc_i,
    input  logic [DFW-1:0] disp_i,
    output logic [AW-1:0]  ea_o,
    output logic [AW-1:0]  wb_data_o,
    output logic           wb_en_o,
    output logic           misalign_o
);
    localparam int SHORT_W = 4;
    localparam int MID_W   = 8;

    logic [AW-1:0] step;
    logic [AW-1:0] off4;
    logic [AW-1:0] off8;
    logic [AW-1:0] pc_base;
    logic [AW-1:0] br_short;
    logic [AW-1:0] br_long;
    logic [AW-1:0] br_reg;
    logic [AW-1:0] inc_val;
    logic [AW-1:0] dec_val;
    logic          is_data;

    // Auto-modify step in bytes from the size code.
    always_comb begin
        unique case (size_i)
            2'd0:    step = AW'(1);
            2'd1:    step = AW'(2);
            default: step = AW'(4);
        endcase
    end

    ea_disp_scale #(.DW(SHORT_W), .AW(AW)) u_scale4 (
        .disp_i  (disp_i[SHORT_W-1:0]),
        .size_i  (size_i),
        .scaled_o(off4)
    );

    ea_disp_scale #(.DW(MID_W), .AW(AW)) u_scale8 (
        .disp_i  (disp_i[MID_W-1:0]),
        .size_i  (size_i),
        .scaled_o(off8)
    );

    ea_branch_calc #(.AW(AW), .SDW(MID_W), .LDW(DFW)) u_branch (
        .pc_i       (pc_i),
        .reg_i      (base_i),
        .disp_i     (disp_i),
        .short_tgt_o(br_short),
        .long_tgt_o (br_long),
        .reg_tgt_o  (br_reg)
    );

    // Long PC-relative loads drop the two low PC bits.
    always_comb begin
        pc_base = (size_i[1]) ? (pc_i & ~AW'(3)) : pc_i;
    end

    // Auto-modify sums.
    always_comb begin
        inc_val = base_i + step;
        dec_val = base_i - step;
    end

    // Select the address for the decoded mode.
    always_comb begin
        is_data = 1'b1;
        unique case (mode_i)
            M_IND:     ea_o = base_i;
            M_POSTINC: ea_o = base_i;
            M_PREDEC:  ea_o = dec_val;
            M_DISP4:   ea_o = base_i + off4;
            M_IDX_RN:  ea_o = base_i + r0_i;
            M_GBR_D8:  ea_o = gbr_i + off8;
            M_GBR_IDX: ea_o = gbr_i + r0_i;
            M_PC_D8:   ea_o = pc_base + off8;
            M_BR8:     begin ea_o = br_short; is_data = 1'b0; end
            M_BR12:    begin ea_o = br_long;  is_data = 1'b0; end
            M_BR_REG:  begin ea_o = br_reg;   is_data = 1'b0; end
            default:   begin ea_o = '0;       is_data = 1'b0; end
        endcase
    end

    // Base writeback for the two auto-modify modes only.
    always_comb begin
        unique case (mode_i)
            M_POSTINC: begin wb_en_o = 1'b1; wb_data_o = inc_val; end
            M_PREDEC:  begin wb_en_o = 1'b1; wb_data_o = dec_val; end
            default:   begin wb_en_o = 1'b0; wb_data_o = '0;      end
        endcase
    end

    ea_align_chk #(.AW(AW)) u_align (
        .addr_i    (ea_o),
        .size_i    (size_i),
        .en_i      (is_data),
        .misalign_o(misalign_o)
    );

    // Writeback checks beside the writeback logic.
    always_comb begin
        if (mode_i > 4'd2 || mode_i == 4'd0)
            assert_wb_only_automod_R12: assert (!wb_en_o && wb_data_o == '0)
                else $error("writeback outside auto-modify modes");
        if (mode_i == 4'd1)
            assert_postinc_step_R2: assert (wb_data_o - ea_o == step && ea_o == base_i)
                else $error("post-increment base update wrong");
        if (mode_i == 4'd2)
            assert_predec_same_R3: assert (ea_o == wb_data_o && base_i - ea_o == step)
                else $error("pre-decrement address differs from writeback");
    end

    // Branch targets keep the PC's even/odd bit since offsets are doubled.
    always_comb begin
        if (mode_i == 4'd8 || mode_i == 4'd9)
            assert_branch_parity_R8: assert (ea_o[0] == pc_i[0])
                else $error("branch offset not doubled");
        if (mode_i > 4'd10)
            assert_reserved_quiet_R12: assert (ea_o == '0 && !misalign_o)
                else $error("reserved mode produced output");
    end
endmodule

// File: tb/ea_addr_gen_tb.sv
// Bench for ea_addr_gen: directed corners plus seeded random vectors,
// compared against a model written from the requirements.
module ea_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic [3:0]  mode;
    logic [1:0]  size;
    logic [31:0] base, r0, gbr, pc;
    logic [11:0] disp;
    logic [31:0] ea, wbd;
    logic        wbe, mis;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    ea_addr_gen dut_i (
        .mode_i(mode), .size_i(size), .base_i(base), .r0_i(r0),
        .gbr_i(gbr), .pc_i(pc), .disp_i(disp),
        .ea_o(ea), .wb_data_o(wbd), .wb_en_o(wbe), .misalign_o(mis)
    );

    function automatic logic [31:0] stp(input logic [1:0] s);
        return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
    endfunction

    function automatic logic [31:0] exp_ea(input logic [3:0] m, input logic [1:0] s,
        input logic [31:0] b, input logic [31:0] x, input logic [31:0] g,
        input logic [31:0] p, input logic [11:0] d);
        logic [31:0] z4, z8;
        z4 = {28'd0, d[3:0]} * stp(s);
        z8 = {24'd0, d[7:0]} * stp(s);
        case (m)
            4'd0, 4'd1: return b;
            4'd2:  return b - stp(s);
            4'd3:  return b + z4;
            4'd4:  return b + x;
            4'd5:  return g + z8;
            4'd6:  return g + x;
            4'd7:  return (s >= 2'd2) ? {p[31:2], 2'b00} + z8 : p + z8;
            4'd8:  return p + {{23{d[7]}}, d[7:0], 1'b0};
            4'd9:  return p + {{19{d[11]}}, d[11:0], 1'b0};
            4'd10: return p + b;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";
            4'd3: return "R4";  4'd4: return "R5";  4'd5: return "R6";
            4'd6: return "R5";  4'd7: return "R7";  4'd8: return "R8";
            4'd9: return "R9";  4'd10: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive at a rising edge, compare at the following falling edge.
    task automatic apply(input logic [3:0] m, input logic [1:0] s,
        input logic [31:0] b, input logic [31:0] x, input logic [31:0] g,
        input logic [31:0] p, input logic [11:0] d, input string req);
        logic [31:0] e, ew;
        logic        ewe, em;
        @(posedge clk);
        mode = m; size = s; base = b; r0 = x; gbr = g; pc = p; disp = d;
        @(negedge clk);
        e   = exp_ea(m, s, b, x, g, p, d);
        ewe = (m == 4'd1 || m == 4'd2);
        ew  = (m == 4'd1) ? b + stp(s) : (m == 4'd2) ? b - stp(s) : 32'd0;
        em  = (m <= 4'd7) && ((s == 2'd1 && e[0]) || (s >= 2'd2 && e[1:0] != 2'b00));
        check(req, "ea", ea, e);
        check((ewe ? req : "R12"), "wb_en", {31'd0, wbe}, {31'd0, ewe});
        check((ewe ? req : "R12"), "wb_data", wbd, ew);
        check("R11", "misalign", {31'd0, mis}, {31'd0, em});
    endtask

    initial begin
        mode = 4'd0; size = 2'd0; base = '0; r0 = '0; gbr = '0; pc = '0; disp = '0;
        @(negedge clk);
        check("R1", "idle ea", ea, 32'd0);
        check("R12", "idle wb_en", {31'd0, wbe}, 32'd0);

        apply(4'd0, 2'd2, 32'h0000_1003, 0, 0, 0, 0, "R1");
        apply(4'd1, 2'd2, 32'h0000_1000, 0, 0, 0, 0, "R2");
        apply(4'd1, 2'd3, 32'hFFFF_FFFC, 0, 0, 0, 0, "R13");
        apply(4'd2, 2'd1, 32'h0000_1000, 0, 0, 0, 0, "R3");
        apply(4'd2, 2'd0, 32'h0000_0000, 0, 0, 0, 0, "R13");
        apply(4'd3, 2'd2, 32'h0000_2000, 0, 0, 0, 12'hFFF, "R4");
        apply(4'd3, 2'd1, 32'h0000_2001, 0, 0, 0, 12'h00F, "R11");
        apply(4'd4, 2'd0, 32'hFFFF_FFFF, 32'd2, 0, 0, 0, "R5");
        apply(4'd6, 2'd2, 0, 32'h10, 32'h8000_0000, 0, 0, "R5");
        apply(4'd5, 2'd2, 0, 0, 32'h0000_4000, 0, 12'h0FF, "R6");
        apply(4'd7, 2'd2, 0, 0, 0, 32'h0000_1006, 12'h001, "R7");
        apply(4'd7, 2'd1, 0, 0, 0, 32'h0000_1006, 12'h001, "R7");
        apply(4'd7, 2'd0, 0, 0, 0, 32'h0000_1006, 12'h0FF, "R7");
        apply(4'd8, 2'd1, 0, 0, 0, 32'h0000_1000, 12'h080, "R8");
        apply(4'd8, 2'd2, 0, 0, 0, 32'h0000_1002, 12'h07F, "R8");
        apply(4'd9, 2'd0, 0, 0, 0, 32'h0000_0004, 12'h800, "R9");
        apply(4'd9, 2'd0, 0, 0, 0, 32'h0000_0004, 12'h7FF, "R9");
        apply(4'd10, 2'd2, 32'hFFFF_FFF0, 0, 0, 32'h0000_0100, 0, "R10");
        apply(4'd13, 2'd1, 32'h1234_5677, 32'd1, 32'd3, 32'd5, 12'hABC, "R12");

        void'($urandom(32'd24681));
        for (int i = 0; i < 400; i++) begin
            logic [3:0] m;
            m = 4'($urandom_range(0, 15));
            apply(m, 2'($urandom_range(0, 3)), $urandom, $urandom, $urandom,
                  $urandom, 12'($urandom), tag_of(m));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule